// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns each processor bus address into a single select line. It has four programmable external channels and two internal windows at fixed locations. The bus carries 16-bit data and a 24-bit physical address. Every channel holds two 16-bit configuration words. The base word gives the region's start address. The option word gives a compare mask, which sets the region size and its mirroring, plus a read-only flag and an enable flag. The address is compared with each enabled channel under that channel's mask. Address bits that the mask leaves out make the region repeat at mirror addresses across the 16 MB space.

Two windows are decoded at fixed addresses that no channel setting can move: a 2 KB internal RAM and a 2 KB internal register block. Because of this, code running from internal RAM keeps working while software rewrites channel 0. Software typically moves the boot ROM from address zero up to 0xF80000 and hands the bottom of memory to a RAM channel. Out of reset, channel 0 already maps a read-only 256 KB boot ROM at address zero, so the first vector fetches succeed.

The decode is combinational and is computed from the current bus inputs and the registered configuration. Configuration writes use a plain strobe port. A write changes the registers only at the clock edge that samples the strobe, so the decode in progress is never changed mid-cycle. Both interfaces are plain control pins with no valid/ready handshake. The decoder always accepts an address and always accepts a configuration write, so it never applies back-pressure.

Top module: `cs_decode_unit`

## Requirements
- R1: After reset, channel 0 holds base 0x0000 and option 0xFC03. This maps a read-only 256 KB region at address 0x000000. Channels 1 to 3 hold zero and are disabled. A read of address 0 asserts cs_sel[0].
- R2: Address bits above bit 23 of bus_addr have no effect on any output.
- R3: Option bits [15:5] are a compare mask for address bits A23..A13, one bit per address bit. Base bits [15:5] give the matching values for A23..A13. A channel matches when every masked address bit equals its base bit, so cleared mask bits produce mirror copies of the region.
- R4: Option bit 1 set marks a channel read-only. On a write cycle, a read-only channel does not match, and decoding falls through to the next channel.
- R5: Option bit 0 is the channel enable. A channel with this bit clear never asserts its select.
- R6: When several channels match, only the lowest-numbered one is selected.
- R7: Addresses 0xFC6000–0xFC67FF assert iram_sel and addresses 0xFC6800–0xFC6FFF assert ireg_sel. Channel settings never affect these windows, and both windows take priority over every channel.
- R8: With bus_valid high and no match, no_sel is asserted. With bus_valid low, every output is low.
- R9: Register index 2*n addresses the base word of channel n, and index 2*n+1 addresses its option word. A write becomes visible at the clock edge that samples cfg_we, and the decode is unchanged before that edge.
- R10: At most one of cs_sel, iram_sel, ireg_sel and no_sel is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, restores the boot mapping |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Register index: 2*channel, plus 1 for the option word |
| cfg_wdata | input | 16 | Configuration write data |
| bus_valid | input | 1 | An access is in progress |
| bus_addr | input | 32 | Access address; bits above 23 are ignored |
| bus_write | input | 1 | The access is a write |
| cs_sel | output | 4 | External channel selects, at most one high |
| iram_sel | output | 1 | Internal RAM window selected |
| ireg_sel | output | 1 | Internal register window selected |
| no_sel | output | 1 | Valid access that matched nothing |

## Verification
The bench sweeps every 8 KB block of the 24-bit space under three mappings: the reset boot map, the remapped map with a mirrored channel, and an overlapping map with a disabled channel and a read-only low channel. Each address carries junk in the high bits. A decoder that compared bits above A23, or that ignored the mask, would select the wrong mirror or miss the mirror copies. One that let a read-only ROM answer writes, or did not fall through to the next channel, would send writes to the ROM. A wrong priority order would fire the higher channel where channels overlap. The bench also probes both edges of the two internal windows while a channel covers them, so a window that lost priority or was off by one block shows up. Finally, it checks the decode just before and just after the edge that commits a base write, so an early or late update is caught.

// File: rtl/cs_decode_pkg.sv
package cs_decode_pkg;

  localparam int unsigned CFG_W      = 16;
  localparam int unsigned OPT_EN_BIT = 0;
  localparam int unsigned OPT_RO_BIT = 1;

  typedef struct packed {
    logic [CFG_W-1:0] base;
    logic [CFG_W-1:0] opt;
  } chan_cfg_t;

  function automatic logic chan_enabled(chan_cfg_t c);
    return c.opt[OPT_EN_BIT];
  endfunction

  function automatic logic chan_read_only(chan_cfg_t c);
    return c.opt[OPT_RO_BIT];
  endfunction

endpackage

// File: rtl/cs_cfg_bank.sv
module cs_cfg_bank
  import cs_decode_pkg::*;
#(
  parameter int unsigned NCH      = 4,
  parameter int unsigned IDXW     = 3,
  parameter logic [15:0] RST_BASE0 = 16'h0000,
  parameter logic [15:0] RST_OPT0  = 16'hFC03
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDXW-1:0]     cfg_idx,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output chan_cfg_t [NCH-1:0] cfg_o
);

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    localparam logic [CFG_W-1:0] RB = (g == 0) ? RST_BASE0 : '0;
    localparam logic [CFG_W-1:0] RO = (g == 0) ? RST_OPT0  : '0;
    logic sel;
    assign sel = cfg_we && ((cfg_idx >> 1) == IDXW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_o[g].base <= RB;
        cfg_o[g].opt  <= RO;
      end else if (sel) begin
        if (cfg_idx[0]) cfg_o[g].opt  <= cfg_wdata;
        else            cfg_o[g].base <= cfg_wdata;
      end
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_o)) else $error("config changed without write"); // R9

  AST_CFG_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_idx[0] && ((cfg_idx >> 1) < IDXW'(NCH))
    |=> cfg_o[$past(cfg_idx) >> 1].opt == $past(cfg_wdata)) else $error("option write lost"); // R9

endmodule

// File: rtl/cs_chan_match.sv
module cs_chan_match
  import cs_decode_pkg::*;
#(
  parameter int unsigned CMPW = 11
) (
  input  logic [CMPW-1:0] addr_hi,
  input  logic            is_write,
  input  chan_cfg_t       cfg,
  output logic            hit
);

  logic [CMPW-1:0] mask, base_hi;
  logic            unused_cfg_bits;

  assign mask    = cfg.opt[CFG_W-1 -: CMPW];
  assign base_hi = cfg.base[CFG_W-1 -: CMPW];
  assign unused_cfg_bits = ^{cfg.base[CFG_W-1-CMPW:0], cfg.opt[CFG_W-1-CMPW:2]};

  always_comb begin
    hit = chan_enabled(cfg)
       && !(is_write && chan_read_only(cfg))
       && (((addr_hi ^ base_hi) & mask) == '0);
  end

endmodule

// File: rtl/cs_select_pick.sv
module cs_select_pick #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid,
  input  logic           iram_hit,
  input  logic           ireg_hit,
  input  logic [NCH-1:0] ch_hit,
  output logic [NCH-1:0] cs_sel,
  output logic           iram_sel,
  output logic           ireg_sel,
  output logic           no_sel
);

  always_comb begin
    cs_sel   = '0;
    iram_sel = 1'b0;
    ireg_sel = 1'b0;
    no_sel   = 1'b0;
    if (valid) begin
      if (iram_hit)      iram_sel = 1'b1;
      else if (ireg_hit) ireg_sel = 1'b1;
      else if (ch_hit == '0) no_sel = 1'b1;
      else begin
        for (int i = NCH - 1; i >= 0; i--) begin
          if (ch_hit[i]) cs_sel = NCH'(1) << i;
        end
      end
    end
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_sel, iram_sel, ireg_sel, no_sel})) else $error("multiple selects"); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ({cs_sel, iram_sel, ireg_sel, no_sel} == '0)) else $error("select while idle"); // R8

  AST_LOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sel != '0) |-> ((ch_hit & (cs_sel - NCH'(1))) == '0)) else $error("lower channel skipped"); // R6

  AST_INT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    valid && (iram_hit || ireg_hit) |-> cs_sel == '0) else $error("channel beat internal window"); // R7

endmodule

// File: rtl/cs_decode_unit.sv
module cs_decode_unit
  import cs_decode_pkg::*;
#(
  parameter int unsigned NCH        = 4,
  parameter int unsigned AW         = 24,
  parameter int unsigned BUS_AW     = 32,
  parameter int unsigned GRAN_LOG2  = 13,
  parameter int unsigned IWIN_LOG2  = 11,
  parameter int unsigned IRAM_BASE  = 32'h00FC_6000,
  parameter int unsigned IREG_BASE  = 32'h00FC_6800,
  localparam int unsigned IDXW      = $clog2(2 * NCH),
  localparam int unsigned CMPW      = AW - GRAN_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDXW-1:0]   cfg_idx,
  input  logic [15:0]       cfg_wdata,
  input  logic              bus_valid,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_write,
  output logic [NCH-1:0]    cs_sel,
  output logic              iram_sel,
  output logic              ireg_sel,
  output logic              no_sel
);

  localparam int unsigned WINW = AW - IWIN_LOG2;
  localparam logic [AW-1:0] IRAM_B = AW'(IRAM_BASE);
  localparam logic [AW-1:0] IREG_B = AW'(IREG_BASE);

  chan_cfg_t [NCH-1:0] cfg;
  logic [AW-1:0]       phys;
  logic [NCH-1:0]      ch_hit;
  logic                iram_hit, ireg_hit;
  logic                unused_addr_bits;

  assign phys = bus_addr[AW-1:0];
  assign unused_addr_bits = ^{bus_addr[BUS_AW-1:AW], bus_addr[IWIN_LOG2-1:0]};

  assign iram_hit = (phys[AW-1 -: WINW] == IRAM_B[AW-1 -: WINW]);
  assign ireg_hit = (phys[AW-1 -: WINW] == IREG_B[AW-1 -: WINW]);

  cs_cfg_bank #(.NCH(NCH), .IDXW(IDXW)) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_o(cfg)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_match
    cs_chan_match #(.CMPW(CMPW)) u_match (
      .addr_hi(phys[AW-1 -: CMPW]), .is_write(bus_write),
      .cfg(cfg[g]), .hit(ch_hit[g])
    );

    AST_RO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_write && cs_sel[g] |-> !chan_read_only(cfg[g])) else $error("read-only region took a write"); // R4

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_enabled(cfg[g]) |-> !cs_sel[g]) else $error("disabled channel selected"); // R5
  end

  cs_select_pick #(.NCH(NCH)) u_pick (
    .clk(clk), .rst_n(rst_n), .valid(bus_valid),
    .iram_hit(iram_hit), .ireg_hit(ireg_hit), .ch_hit(ch_hit),
    .cs_sel(cs_sel), .iram_sel(iram_sel), .ireg_sel(ireg_sel), .no_sel(no_sel)
  );

  AST_MISS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !iram_hit && !ireg_hit && (ch_hit == '0) |-> no_sel) else $error("miss not flagged"); // R8

endmodule

// File: tb/cs_decode_unit_test.sv
module cs_decode_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [15:0] cfg_wdata = '0;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_write = 1'b0;
  logic [3:0]  cs_sel;
  logic        iram_sel, ireg_sel, no_sel;

  int total = 0;
  int bad = 0;
  logic [15:0] sh_base [4];
  logic [15:0] sh_opt  [4];

  always #10 clk = ~clk;

  cs_decode_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_write(bus_write), .cs_sel(cs_sel), .iram_sel(iram_sel),
    .ireg_sel(ireg_sel), .no_sel(no_sel)
  );

  // Expected {no_sel, ireg_sel, iram_sel, cs_sel} from the requirement encodings.
  function automatic logic [6:0] model(logic [31:0] a, logic w, logic v);
    logic [23:0] x = a[23:0];
    if (!v) return 7'b0;
    if (x >= 24'hFC6000 && x <= 24'hFC67FF) return 7'b0010000;
    if (x >= 24'hFC6800 && x <= 24'hFC6FFF) return 7'b0100000;
    for (int i = 0; i < 4; i++) begin
      logic [10:0] m = sh_opt[i][15:5];
      logic [10:0] b = sh_base[i][15:5];
      if (sh_opt[i][0] && !(w && sh_opt[i][1]) && (((x[23:13] ^ b) & m) == 11'd0))
        return 7'(1 << i);
    end
    return 7'b1000000;
  endfunction

  function automatic logic [6:0] outs();
    return {no_sel, ireg_sel, iram_sel, cs_sel};
  endfunction

  task automatic check(string req, logic [6:0] got, logic [6:0] exp, logic [31:0] a);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s addr=%h got=%b exp=%b", req, a, got, exp);
    end
  endtask

  task automatic probe(string req, logic [31:0] a, logic w, logic v);
    bus_addr = a; bus_write = w; bus_valid = v;
    #1;
    check(req, outs(), model(a, w, v), a);
  endtask

  task automatic cfg_write(int idx, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx[0]) sh_opt[idx >> 1] = d; else sh_base[idx >> 1] = d;
  endtask

  // R2 R3 R4 R5 R6: every 8 KB block, both directions, junk above bit 23
  task automatic sweep(string req);
    for (int k = 0; k < 2048; k++) begin
      logic [31:0] a = {8'((k * 37) ^ 8'h5A), 11'(k), 13'((k * 97) & 13'h1FFF)};
      probe(req, a, 1'b0, 1'b1);
      probe(req, a, 1'b1, 1'b1);
    end
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    sh_base[0] = 16'h0000; sh_opt[0] = 16'hFC03;
    for (int i = 1; i < 4; i++) begin sh_base[i] = '0; sh_opt[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset mapping: ROM at 0 for reads, not for writes
    probe("R1", 32'h0000_0000, 1'b0, 1'b1);
    check("R1", outs(), 7'b0000001, 32'h0);
    probe("R1", 32'h0003_FFFE, 1'b0, 1'b1);
    check("R1", outs(), 7'b0000001, 32'h3FFFE);
    probe("R4", 32'h0000_0000, 1'b1, 1'b1);
    check("R4", outs(), 7'b1000000, 32'h0);
    probe("R8", 32'h0000_0000, 1'b0, 1'b0);
    check("R8", outs(), 7'b0000000, 32'h0);
    sweep("R3");

    // R9: base write seen only after the sampling edge
    bus_addr = 32'h0; bus_write = 1'b0; bus_valid = 1'b1;
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd0; cfg_wdata = 16'hF800;
    #5;
    check("R9", outs(), 7'b0000001, 32'h0);
    @(posedge clk); #1;
    check("R9", outs(), 7'b1000000, 32'h0);
    @(negedge clk); cfg_we = 1'b0; sh_base[0] = 16'hF800;
    probe("R9", 32'h00F8_0000, 1'b0, 1'b1);
    check("R9", outs(), 7'b0000001, 32'hF80000);

    // remapped layout with a mirrored channel 2
    cfg_write(3, 16'hF801);
    cfg_write(5, 16'h3F01);
    cfg_write(4, 16'h4000);
    cfg_write(7, 16'hFFE1);
    cfg_write(6, 16'hFC00);
    probe("R3", 32'h0040_8000, 1'b1, 1'b1); check("R3", outs(), 7'b0000100, 32'h408000);
    probe("R3", 32'h0080_8000, 1'b0, 1'b1); check("R3", outs(), 7'b0000100, 32'h808000);
    probe("R3", 32'h00C0_8000, 1'b1, 1'b1); check("R3", outs(), 7'b0000100, 32'hC08000);
    probe("R2", 32'hAB00_0010, 1'b1, 1'b1); check("R2", outs(), 7'b0000010, 32'hAB000010);
    probe("R2", 32'h0FF8_0000, 1'b0, 1'b1); check("R2", outs(), 7'b0000001, 32'h0FF80000);
    sweep("R6");

    // overlap: ch3 covers 1 MB at 0, ch1 read-only, ch2 disabled, ch0 over windows
    cfg_write(3, 16'hF803);
    cfg_write(6, 16'h0000);
    cfg_write(7, 16'hF001);
    cfg_write(5, 16'h3F00);
    cfg_write(0, 16'hFC00);
    cfg_write(1, 16'hFF01);
    probe("R6", 32'h0001_0000, 1'b0, 1'b1); check("R6", outs(), 7'b0000010, 32'h10000);
    probe("R4", 32'h0001_0000, 1'b1, 1'b1); check("R4", outs(), 7'b0001000, 32'h10000);
    probe("R5", 32'h0040_8000, 1'b0, 1'b1); check("R5", outs(), 7'b1000000, 32'h408000);
    probe("R7", 32'h00FC_5FFF, 1'b0, 1'b1); check("R7", outs(), 7'b0000001, 32'hFC5FFF);
    probe("R7", 32'h00FC_6000, 1'b0, 1'b1); check("R7", outs(), 7'b0010000, 32'hFC6000);
    probe("R7", 32'h00FC_67FF, 1'b1, 1'b1); check("R7", outs(), 7'b0010000, 32'hFC67FF);
    probe("R7", 32'h00FC_6800, 1'b0, 1'b1); check("R7", outs(), 7'b0100000, 32'hFC6800);
    probe("R7", 32'h00FC_6FFF, 1'b1, 1'b1); check("R7", outs(), 7'b0100000, 32'hFC6FFF);
    probe("R7", 32'h00FC_7000, 1'b0, 1'b1); check("R7", outs(), 7'b0000001, 32'hFC7000);
    probe("R10", 32'h00FC_6400, 1'b0, 1'b0); check("R10", outs(), 7'b0000000, 32'hFC6400);
    sweep("R5");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule